// File: doc/BRIEF.md
# Dual-Buffer Block Cipher Sequencer

This block sits between a processor bus and a block cipher engine. It owns two on-chip buffers: a plaintext buffer and a ciphertext buffer, each holding a fixed number of cipher blocks. Software fills the buffers through two address windows. It then programs a start block offset for each buffer, the block count minus one, and, for chained operation, a chaining vector. A write to the control register with the go bit set launches a run. The controller feeds the blocks one at a time to an external cipher engine over a request/acknowledge handshake. Each result goes into the opposite buffer.

The direction comes from the mode bits. Encryption reads plaintext and writes ciphertext. Decryption reads ciphertext and writes plaintext. In chained (CBC) mode the controller folds the chaining vector into each block. It leaves the final chaining value in the vector registers so that software can continue a chained message. When a run ends, a done flag and a pending-interrupt flag are set. The interrupt line can be masked. A zeroize request clears both buffers one word per cycle.

Register map (byte offsets): 0x00 plaintext start block, 0x04 ciphertext start block, 0x08 block count minus one, 0x0C control, 0x10 status, 0x14 error, 0x18 interrupt control, 0x1C configuration, 0x20 upwards chaining vector words (word i holds vector bits [32i+31:32i]). The plaintext window starts at 0x400 and the ciphertext window at 0x800. Word j of block b sits at window + 4*(b*BLOCK_WORDS + j) and holds block bits [32j+31:32j].

Top module: `dbc_cipher_ctrl`

## Requirements
- R1: After reset, status reads 0, control reads 0, every buffer word reads 0 and the interrupt output is low.
- R2: Encrypt in ECB mode (control bit 2 set, bit 1 clear, bit 0 clear). Plaintext block ps+k is sent to the engine unchanged and the engine result is written to ciphertext block cs+k, for k from 0 to the count minus one.
- R3: Decrypt in ECB mode (control bit 0 set). Ciphertext block cs+k is sent to the engine with its decrypt input high, and the result is written to plaintext block ps+k.
- R4: Encrypt in CBC mode (control bit 1 set). The engine receives the plaintext block XOR the chaining vector. Each result becomes the new vector, and the last ciphertext block stays readable at 0x20 upwards after completion.
- R5: Decrypt in CBC mode. The output is the engine result XOR the chaining vector. The consumed ciphertext block becomes the new vector, and the last input block stays readable after completion.
- R6: The length register holds the block count minus one. Exactly that many blocks plus one are written, and every other buffer block keeps its value.
- R7: From the go write until the last result is stored, status bit 0 (busy) and bit 2 (ciphering) are high. Then busy and ciphering drop, and bit 10 (done) and bit 8 (interrupt pending) are set.
- R8: If either start offset plus the block count exceeds the buffer size in blocks, then: status bit 12 and error register bit 0 are set, busy never rises, and no buffer word changes. Any write to the error register clears the flag.
- R9: The interrupt output equals pending AND NOT mask, where the mask is interrupt control bit 0. Writing interrupt control with bit 1 set clears pending.
- R10: Writing interrupt control with bit 2 set while idle clears both buffers. Busy (bit 0) and zeroizing (bit 1) are held for exactly one cycle per buffer word, and then status bit 9 (zeroize done) is set.
- R11: The configuration register is read-only and reads BLOCK_WORDS*4 in bits [6:0], the plaintext buffer size in blocks in bits [16:7] and the ciphertext buffer size in blocks in bits [26:17].
- R12: While busy, bus writes to the buffers, the start, length, control and chaining vector registers are ignored. While an engine request waits for its acknowledge, the engine data stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| eng_req | output | 1 | Block presented to the cipher engine |
| eng_dec | output | 1 | Engine direction, high for decrypt |
| eng_data | output | 32*BLOCK_WORDS | Block to the engine |
| eng_ack | input | 1 | Engine result valid, one cycle |
| eng_result | input | 32*BLOCK_WORDS | Block from the engine |
| irq | output | 1 | Interrupt request |

## Verification
The engine stub in the bench applies a keyed rotate-and-XOR whose inverse is known. A wrong direction, a missing chaining XOR or a misplaced vector update each show up as a different block value. ECB runs in both directions show whether the source and destination buffers are swapped. CBC runs in both directions show whether the chaining value comes from the engine output or from the consumed input. A sweep over every start offset and every block count shows the exact boundary of the length check, and shows whether blocks outside the window stay untouched. Separate runs cover masking, writes made during a run, and the zeroize cycle count.

// File: rtl/dbc_pkg.sv
package dbc_pkg;
    localparam int OFS_W   = 10;
    localparam int IV_BASE = 8;

    localparam logic [3:0] REG_PSTART = 4'd0;
    localparam logic [3:0] REG_CSTART = 4'd1;
    localparam logic [3:0] REG_LEN    = 4'd2;
    localparam logic [3:0] REG_CTRL   = 4'd3;
    localparam logic [3:0] REG_STAT   = 4'd4;
    localparam logic [3:0] REG_ERR    = 4'd5;
    localparam logic [3:0] REG_INTC   = 4'd6;
    localparam logic [3:0] REG_CFG    = 4'd7;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_ZERO = 2'd2
    } seq_state_e;
endpackage

// File: rtl/dbc_buffer.sv
module dbc_buffer #(
    parameter int BLOCK_WORDS = 2,
    parameter int NUM_BLOCKS  = 8,
    localparam int WORD_W     = 32,
    localparam int NUM_WORDS  = BLOCK_WORDS * NUM_BLOCKS,
    localparam int BLK_IW     = $clog2(NUM_BLOCKS),
    localparam int WORD_IW    = $clog2(NUM_WORDS),
    localparam int BLOCK_W    = WORD_W * BLOCK_WORDS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [WORD_IW-1:0] bus_idx,
    input  logic [WORD_W-1:0]  bus_wdata,
    output logic [WORD_W-1:0]  bus_rdata,
    input  logic               blk_we,
    input  logic [BLK_IW-1:0]  blk_widx,
    input  logic [BLOCK_W-1:0] blk_wdata,
    input  logic [BLK_IW-1:0]  blk_ridx,
    output logic [BLOCK_W-1:0] blk_rdata,
    input  logic               clr_en,
    input  logic [WORD_IW-1:0] clr_idx
);
    logic [WORD_W-1:0] mem_d [NUM_WORDS];
    logic [WORD_W-1:0] mem_q [NUM_WORDS];

    always_comb begin
        mem_d = mem_q;
        if (bus_we) begin
            mem_d[bus_idx] = bus_wdata;
        end
        if (blk_we) begin
            for (int w = 0; w < BLOCK_WORDS; w++) begin
                mem_d[WORD_IW'(int'(blk_widx) * BLOCK_WORDS + w)] = blk_wdata[w*WORD_W +: WORD_W];
            end
        end
        if (clr_en) begin
            mem_d[clr_idx] = '0;
        end
    end

    always_comb begin
        for (int w = 0; w < BLOCK_WORDS; w++) begin
            blk_rdata[w*WORD_W +: WORD_W] = mem_q[WORD_IW'(int'(blk_ridx) * BLOCK_WORDS + w)];
        end
    end

    assign bus_rdata = mem_q[bus_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '{default: '0};
        end else begin
            mem_q <= mem_d;
        end
    end
endmodule

// File: rtl/dbc_seq.sv
module dbc_seq
    import dbc_pkg::*;
#(
    parameter int BLOCK_WORDS = 2,
    parameter int BUF_BLOCKS  = 8,
    localparam int WORD_W     = 32,
    localparam int BLOCK_W    = WORD_W * BLOCK_WORDS,
    localparam int BUF_WORDS  = BLOCK_WORDS * BUF_BLOCKS,
    localparam int BLK_IW     = $clog2(BUF_BLOCKS),
    localparam int WORD_IW    = $clog2(BUF_WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [3:0]         reg_idx,
    input  logic [WORD_W-1:0]  wdata,
    output logic [WORD_W-1:0]  reg_rdata,
    output logic               busy,
    output logic               src_is_ciph,
    input  logic [BLOCK_W-1:0] src_blk,
    output logic [BLK_IW-1:0]  blk_ridx,
    output logic [BLK_IW-1:0]  blk_widx,
    output logic [BLOCK_W-1:0] blk_wdata,
    output logic               plain_we,
    output logic               ciph_we,
    output logic               clr_en,
    output logic [WORD_IW-1:0] clr_idx,
    output logic               eng_req,
    output logic               eng_dec,
    output logic [BLOCK_W-1:0] eng_data,
    input  logic               eng_ack,
    input  logic [BLOCK_W-1:0] eng_result,
    output logic               irq
);
    localparam logic [OFS_W+1:0] LIMIT    = (OFS_W + 2)'(BUF_BLOCKS);
    localparam logic [WORD_W-1:0] CFG_WORD = WORD_W'(BLOCK_WORDS * 4)
                                           | (WORD_W'(BUF_BLOCKS) << 7)
                                           | (WORD_W'(BUF_BLOCKS) << 17);

    typedef struct packed {
        seq_state_e         st;
        logic [BLK_IW-1:0]  cnt;
        logic [WORD_IW-1:0] zidx;
        logic [OFS_W-1:0]   pstart;
        logic [OFS_W-1:0]   cstart;
        logic [OFS_W-1:0]   len;
        logic               cbc;
        logic               dec;
        logic               len_err;
        logic               done;
        logic               zdone;
        logic               pend;
        logic               mask;
        logic [BLOCK_W-1:0] iv;
    } seq_t;

    seq_t s_d, s_q;

    logic               idle;
    logic [OFS_W-1:0]   src_ofs, dst_ofs;
    logic [OFS_W+1:0]   need_p, need_c;
    logic [BLOCK_W-1:0] out_blk;

    always_comb begin
        s_d     = s_q;
        idle    = (s_q.st == S_IDLE);
        src_ofs = s_q.dec ? s_q.cstart : s_q.pstart;
        dst_ofs = s_q.dec ? s_q.pstart : s_q.cstart;
        need_p  = (OFS_W + 2)'(s_q.pstart) + (OFS_W + 2)'(s_q.len) + 1'b1;
        need_c  = (OFS_W + 2)'(s_q.cstart) + (OFS_W + 2)'(s_q.len) + 1'b1;

        blk_ridx  = BLK_IW'(src_ofs + OFS_W'(s_q.cnt));
        blk_widx  = BLK_IW'(dst_ofs + OFS_W'(s_q.cnt));
        eng_req   = (s_q.st == S_RUN);
        eng_dec   = s_q.dec;
        eng_data  = src_blk ^ ((s_q.cbc && !s_q.dec) ? s_q.iv : '0);
        out_blk   = s_q.dec ? (eng_result ^ (s_q.cbc ? s_q.iv : '0)) : eng_result;
        blk_wdata = out_blk;
        plain_we  = eng_req && eng_ack && s_q.dec;
        ciph_we   = eng_req && eng_ack && !s_q.dec;
        clr_en    = (s_q.st == S_ZERO);
        clr_idx   = s_q.zidx;

        // bus register writes
        if (reg_wr) begin
            unique case (reg_idx)
                REG_PSTART: if (idle) s_d.pstart = wdata[OFS_W-1:0];
                REG_CSTART: if (idle) s_d.cstart = wdata[OFS_W-1:0];
                REG_LEN:    if (idle) s_d.len    = wdata[OFS_W-1:0];
                REG_CTRL: begin
                    if (idle) begin
                        s_d.cbc = wdata[1];
                        s_d.dec = wdata[0];
                        if (wdata[2]) begin
                            s_d.done = 1'b0;
                            if ((need_p > LIMIT) || (need_c > LIMIT)) begin
                                s_d.len_err = 1'b1;
                            end else begin
                                s_d.len_err = 1'b0;
                                s_d.st      = S_RUN;
                                s_d.cnt     = '0;
                            end
                        end
                    end
                end
                REG_ERR: s_d.len_err = 1'b0;
                REG_INTC: begin
                    s_d.mask = wdata[0];
                    if (wdata[1]) s_d.pend = 1'b0;
                    if (wdata[2] && idle) begin
                        s_d.st    = S_ZERO;
                        s_d.zidx  = '0;
                        s_d.zdone = 1'b0;
                    end
                end
                default: begin
                    for (int w = 0; w < BLOCK_WORDS; w++) begin
                        if (idle && (reg_idx == 4'(IV_BASE + w))) begin
                            s_d.iv[w*WORD_W +: WORD_W] = wdata;
                        end
                    end
                end
            endcase
        end

        // sequencing
        if ((s_q.st == S_RUN) && eng_ack) begin
            if (s_q.cbc) begin
                s_d.iv = s_q.dec ? src_blk : eng_result;
            end
            if (OFS_W'(s_q.cnt) == s_q.len) begin
                s_d.st   = S_IDLE;
                s_d.done = 1'b1;
                s_d.pend = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
        if (s_q.st == S_ZERO) begin
            if (s_q.zidx == WORD_IW'(BUF_WORDS - 1)) begin
                s_d.st    = S_IDLE;
                s_d.zdone = 1'b1;
            end else begin
                s_d.zidx = s_q.zidx + 1'b1;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_idx)
            REG_PSTART: reg_rdata = WORD_W'(s_q.pstart);
            REG_CSTART: reg_rdata = WORD_W'(s_q.cstart);
            REG_LEN:    reg_rdata = WORD_W'(s_q.len);
            REG_CTRL:   reg_rdata = {29'b0, s_q.st == S_RUN, s_q.cbc, s_q.dec};
            REG_STAT: begin
                reg_rdata[12] = s_q.len_err;
                reg_rdata[10] = s_q.done;
                reg_rdata[9]  = s_q.zdone;
                reg_rdata[8]  = s_q.pend;
                reg_rdata[2]  = (s_q.st == S_RUN);
                reg_rdata[1]  = (s_q.st == S_ZERO);
                reg_rdata[0]  = (s_q.st != S_IDLE);
            end
            REG_ERR:  reg_rdata = {31'b0, s_q.len_err};
            REG_INTC: reg_rdata = {31'b0, s_q.mask};
            REG_CFG:  reg_rdata = CFG_WORD;
            default: begin
                for (int w = 0; w < BLOCK_WORDS; w++) begin
                    if (reg_idx == 4'(IV_BASE + w)) begin
                        reg_rdata = s_q.iv[w*WORD_W +: WORD_W];
                    end
                end
            end
        endcase
    end

    assign busy        = (s_q.st != S_IDLE);
    assign src_is_ciph = s_q.dec;
    assign irq         = s_q.pend && !s_q.mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R7: leaving the run state always leaves done and pending behind
    a_r7_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(s_q.st == S_RUN) && (s_q.st == S_IDLE)) |-> (s_q.done && s_q.pend));

    // R8: a length error never coexists with a run
    a_r8_err_no_run: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.len_err |-> (s_q.st != S_RUN));

    // R6: block counter never passes the programmed length
    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == S_RUN) |-> (OFS_W'(s_q.cnt) <= s_q.len));

    // R10: leaving the clear state always marks zeroize done
    a_r10_zero_done: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(s_q.st == S_ZERO) && (s_q.st == S_IDLE)) |-> s_q.zdone);

    // R12: a waiting engine request keeps its block steady
    a_r12_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_ack) |=> (eng_req && $stable(eng_data)));
endmodule

// File: rtl/dbc_cipher_ctrl.sv
module dbc_cipher_ctrl
    import dbc_pkg::*;
#(
    parameter int BLOCK_WORDS = 2,
    parameter int BUF_BLOCKS  = 8,
    localparam int WORD_W     = 32,
    localparam int BLOCK_W    = WORD_W * BLOCK_WORDS,
    localparam int BUF_WORDS  = BLOCK_WORDS * BUF_BLOCKS,
    localparam int BLK_IW     = $clog2(BUF_BLOCKS),
    localparam int WORD_IW    = $clog2(BUF_WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_en,
    input  logic               bus_we,
    input  logic [11:0]        bus_addr,
    input  logic [WORD_W-1:0]  bus_wdata,
    output logic [WORD_W-1:0]  bus_rdata,
    output logic               eng_req,
    output logic               eng_dec,
    output logic [BLOCK_W-1:0] eng_data,
    input  logic               eng_ack,
    input  logic [BLOCK_W-1:0] eng_result,
    output logic               irq
);
    logic [1:0]         win;
    logic [7:0]         wofs;
    logic               word_ok, reg_hit, wr;
    logic [WORD_W-1:0]  reg_rdata;
    logic               busy, src_is_ciph;
    logic [BLOCK_W-1:0] src_blk, blk_wdata;
    logic [BLK_IW-1:0]  blk_ridx, blk_widx;
    logic               plain_we, ciph_we, clr_en;
    logic [WORD_IW-1:0] clr_idx;

    logic [1:0]         buf_bus_we, buf_blk_we;
    logic [WORD_W-1:0]  buf_bus_rd [2];
    logic [BLOCK_W-1:0] buf_blk_rd [2];
    logic               unused_addr;

    assign win         = bus_addr[11:10];
    assign wofs        = bus_addr[9:2];
    assign word_ok     = (int'(wofs) < BUF_WORDS);
    assign reg_hit     = (win == 2'd0) && (bus_addr[9:6] == 4'd0);
    assign wr          = bus_en && bus_we;
    assign unused_addr = ^bus_addr[1:0];

    assign buf_bus_we[0] = wr && (win == 2'd1) && word_ok && !busy;
    assign buf_bus_we[1] = wr && (win == 2'd2) && word_ok && !busy;
    assign buf_blk_we    = {ciph_we, plain_we};
    assign src_blk       = src_is_ciph ? buf_blk_rd[1] : buf_blk_rd[0];

    always_comb begin
        bus_rdata = '0;
        if (reg_hit) begin
            bus_rdata = reg_rdata;
        end else if (word_ok && (win == 2'd1)) begin
            bus_rdata = buf_bus_rd[0];
        end else if (word_ok && (win == 2'd2)) begin
            bus_rdata = buf_bus_rd[1];
        end
    end

    dbc_seq #(
        .BLOCK_WORDS(BLOCK_WORDS),
        .BUF_BLOCKS (BUF_BLOCKS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (wr && reg_hit),
        .reg_idx    (bus_addr[5:2]),
        .wdata      (bus_wdata),
        .reg_rdata  (reg_rdata),
        .busy       (busy),
        .src_is_ciph(src_is_ciph),
        .src_blk    (src_blk),
        .blk_ridx   (blk_ridx),
        .blk_widx   (blk_widx),
        .blk_wdata  (blk_wdata),
        .plain_we   (plain_we),
        .ciph_we    (ciph_we),
        .clr_en     (clr_en),
        .clr_idx    (clr_idx),
        .eng_req    (eng_req),
        .eng_dec    (eng_dec),
        .eng_data   (eng_data),
        .eng_ack    (eng_ack),
        .eng_result (eng_result),
        .irq        (irq)
    );

    // index 0: plaintext buffer, index 1: ciphertext buffer
    for (genvar g = 0; g < 2; g++) begin : g_buf
        dbc_buffer #(
            .BLOCK_WORDS(BLOCK_WORDS),
            .NUM_BLOCKS (BUF_BLOCKS)
        ) u_buf (
            .clk      (clk),
            .rst_n    (rst_n),
            .bus_we   (buf_bus_we[g]),
            .bus_idx  (wofs[WORD_IW-1:0]),
            .bus_wdata(bus_wdata),
            .bus_rdata(buf_bus_rd[g]),
            .blk_we   (buf_blk_we[g]),
            .blk_widx (blk_widx),
            .blk_wdata(blk_wdata),
            .blk_ridx (blk_ridx),
            .blk_rdata(buf_blk_rd[g]),
            .clr_en   (clr_en),
            .clr_idx  (clr_idx)
        );
    end

    // R12: no buffer takes a bus write while the sequencer is busy
    a_r12_no_bus_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (buf_bus_we == 2'b00));
endmodule

// File: tb/dbc_cipher_ctrl_tb.sv
`timescale 1ns/1ps
module dbc_cipher_ctrl_tb;
    localparam int BW = 2;
    localparam int NB = 8;
    localparam int NW = BW * NB;
    localparam logic [63:0] KEY = 64'h5a3c_96e1_0f87_d2b4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        eng_req, eng_dec, eng_ack;
    logic [63:0] eng_data, eng_result;
    logic        irq;
    int          lat;

    always #2 clk = ~clk;

    dbc_cipher_ctrl #(.BLOCK_WORDS(BW), .BUF_BLOCKS(NB)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_req(eng_req), .eng_dec(eng_dec), .eng_data(eng_data),
        .eng_ack(eng_ack), .eng_result(eng_result), .irq(irq)
    );

    function automatic logic [63:0] f_enc(logic [63:0] x);
        return {x[62:0], x[63]} ^ KEY;
    endfunction
    function automatic logic [63:0] f_dec(logic [63:0] y);
        logic [63:0] z;
        z = y ^ KEY;
        return {z[0], z[63:1]};
    endfunction

    // engine stub: fixed latency, one-cycle acknowledge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_ack <= 1'b0; eng_result <= '0; lat <= 0;
        end else if (eng_ack) begin
            eng_ack <= 1'b0; lat <= 0;
        end else if (eng_req) begin
            if (lat == 2) begin
                eng_ack    <= 1'b1;
                eng_result <= eng_dec ? f_dec(eng_data) : f_enc(eng_data);
                lat        <= 0;
            end else begin
                lat <= lat + 1;
            end
        end
    end

    logic [63:0] pm [NB];
    logic [63:0] cm [NB];
    logic [63:0] iv_m;
    int tests = 0;
    int fails = 0;

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic cmp_bufs(string tag);
        int bad_p = 0, bad_c = 0;
        logic [31:0] lo, hi;
        for (int b = 0; b < NB; b++) begin
            rd(12'(12'h400 + b * 8), lo); rd(12'(12'h404 + b * 8), hi);
            if ({hi, lo} !== pm[b]) bad_p++;
            rd(12'(12'h800 + b * 8), lo); rd(12'(12'h804 + b * 8), hi);
            if ({hi, lo} !== cm[b]) bad_c++;
        end
        chk({tag, " plaintext buffer mismatches"}, 64'(bad_p), 64'd0);
        chk({tag, " ciphertext buffer mismatches"}, 64'(bad_c), 64'd0);
    endtask

    task automatic wait_idle();
        logic [31:0] st;
        int n = 0;
        do begin
            rd(12'h010, st);
            n++;
        end while (st[0] && n < 2000);
    endtask

    task automatic run_op(int ps, int cs, int n, bit cbc, bit dec, string tag);
        logic [31:0] st, lo, hi;
        bit err;
        logic [63:0] x, r;
        err = (ps + n > NB) || (cs + n > NB);
        wr(12'h000, 32'(ps));
        wr(12'h004, 32'(cs));
        wr(12'h008, 32'(n - 1));
        if (cbc) begin
            wr(12'h020, iv_m[31:0]);
            wr(12'h024, iv_m[63:32]);
        end
        wr(12'h00C, {29'b0, 1'b1, cbc, dec});
        rd(12'h010, st);
        if (err) begin
            chk({"R8 length error and no busy ", tag}, {st[12], st[0]}, 2'b10);
        end else begin
            chk({"R7 busy and ciphering after go ", tag}, st[2:0], 3'b101);
        end
        wait_idle();
        if (!err) begin
            rd(12'h010, st);
            chk({"R7 done, pending, not busy ", tag}, {st[10], st[8], st[2], st[0]}, 4'b1100);
            for (int k = 0; k < n; k++) begin
                if (!dec) begin
                    x = cbc ? (pm[ps + k] ^ iv_m) : pm[ps + k];
                    r = f_enc(x);
                    cm[cs + k] = r;
                    if (cbc) iv_m = r;
                end else begin
                    x = cm[cs + k];
                    r = f_dec(x);
                    pm[ps + k] = cbc ? (r ^ iv_m) : r;
                    if (cbc) iv_m = x;
                end
            end
        end
        cmp_bufs(tag);
        if (cbc && !err) begin
            rd(12'h020, lo); rd(12'h024, hi);
            chk({tag, " final chaining vector"}, {hi, lo}, iv_m);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int cnt;
        for (int b = 0; b < NB; b++) begin pm[b] = '0; cm[b] = '0; end
        iv_m = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, R11 configuration
        rd(12'h010, d); chk("R1 status after reset", d, 0);
        rd(12'h00C, d); chk("R1 control after reset", d, 0);
        chk("R1 irq after reset", irq, 0);
        cmp_bufs("R1");
        rd(12'h01C, d); chk("R11 configuration", d, 32'h0010_0408);
        wr(12'h01C, 32'h0);
        rd(12'h01C, d); chk("R11 configuration read-only", d, 32'h0010_0408);

        // load plaintext
        for (int b = 0; b < NB; b++) begin
            pm[b] = 64'h0123_4567_89ab_cdef * 64'(b + 3) + 64'(b);
            wr(12'(12'h400 + b * 8), pm[b][31:0]);
            wr(12'(12'h404 + b * 8), pm[b][63:32]);
        end

        run_op(1, 2, 4, 1'b0, 1'b0, "R2 ECB encrypt");
        chk("R9 irq after done, unmasked", irq, 1);
        wr(12'h018, 32'h2);
        rd(12'h010, d);
        chk("R9 pending cleared", {d[8], irq}, 2'b00);

        run_op(0, 2, 4, 1'b0, 1'b1, "R3 ECB decrypt");
        iv_m = 64'hfeed_0bad_cafe_1234;
        run_op(0, 4, 4, 1'b1, 1'b0, "R4 CBC encrypt");
        iv_m = 64'h1357_9bdf_2468_ace0;
        run_op(4, 4, 4, 1'b1, 1'b1, "R5 CBC decrypt");

        // R6 / R8 sweep over every start offset and block count
        for (int s = 0; s < NB; s++) begin
            for (int n = 1; n <= NB; n++) begin
                run_op(s, 0, n, 1'b0, 1'b0, "R6 sweep");
            end
        end
        run_op(0, 5, 4, 1'b0, 1'b1, "R8 ciphertext start overflow");
        rd(12'h014, d); chk("R8 error register set", d, 1);
        wr(12'h014, 32'h0);
        rd(12'h014, d); chk("R8 error register cleared", d, 0);

        // R9 masking
        wr(12'h018, 32'h3);
        run_op(0, 0, 2, 1'b0, 1'b0, "R9 masked run");
        rd(12'h010, d);
        chk("R9 masked: pending set, irq low", {d[8], irq}, 2'b10);
        wr(12'h018, 32'h0);
        chk("R9 unmasked irq", irq, 1);
        wr(12'h018, 32'h2);
        chk("R9 irq after clear", irq, 0);

        // R12 writes while busy are ignored
        wr(12'h000, 0); wr(12'h004, 0); wr(12'h008, 7);
        wr(12'h00C, 32'h4);
        wr(12'h400, 32'hdead_beef);
        wr(12'h008, 32'h0);
        wr(12'h020, 32'h1111_2222);
        wait_idle();
        for (int k = 0; k < NB; k++) cm[k] = f_enc(pm[k]);
        cmp_bufs("R12 buffer write during run");
        rd(12'h008, d); chk("R12 length write during run", d, 7);
        rd(12'h020, d); chk("R12 vector write during run", d[31:0], iv_m[31:0]);

        // R10 zeroize
        wr(12'h018, 32'h4);
        bus_addr = 12'h010;
        #1;
        cnt = 0;
        while (bus_rdata[0] && bus_rdata[1] && cnt < 100) begin
            cnt++;
            @(negedge clk);
            #1;
        end
        chk("R10 zeroize busy cycles", 64'(cnt), 64'(NW));
        rd(12'h010, d); chk("R10 zeroize done, idle", {d[9], d[1], d[0]}, 3'b100);
        for (int b = 0; b < NB; b++) begin pm[b] = '0; cm[b] = '0; end
        cmp_bufs("R10 buffers cleared");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule